// File: doc/BRIEF.md
# Mixed-Width ADC Bank Unpacker

This block turns one packed front-end bank into 32 full-width ADC samples. A bank arrives as a stream of 32-bit words. The first word is a selector with one bit per channel. Each selector bit says whether that channel's sample was sent as a narrow 4-bit code or as a complete 12-bit value. The words after the selector form a continuous bit stream. Channel fields sit back to back in it, so a field can start in one word and end in the next.

The unpacker holds a small bit reservoir. It reads words through a valid/ready handshake and removes one field per clock. For each channel it presents a 12-bit sample together with the channel number and a strobe. A done flag comes with the last channel of the bank. If the sender marks the final word of a bank before enough bits have arrived, the block raises a one-cycle error and expects a fresh selector word. It does the same if the sender sends more words than the bank needs.

Top module: `adcu_bank_unpacker`

## Requirements
- R1: The first accepted word of a bank is the selector. Bit i of it governs channel i: 1 selects a 12-bit field and 0 selects a 4-bit field.
- R2: Payload fields are taken least significant bit first. They follow each other with no gap, including across word boundaries, and the bit at position k of the stream is bit k%32 of payload word k/32. A 12-bit field is emitted unchanged.
- R3: A 4-bit field is emitted sign-extended to 12 bits, using field bit 3 as the sign.
- R4: Channels come out strictly in order 0 to 31. Each one has `out_valid` high for one cycle and its number on `out_chan`.
- R5: `out_done` is high exactly in the cycle that carries channel 31, and at no other time.
- R6: When input words are offered on every cycle, the 32 channels of a bank come out on 32 consecutive cycles. A bank of all 12-bit channels needs exactly 12 payload words.
- R7: `in_ready` is high while the block waits for a selector word. During a bank it is high only while fewer than 32 unread bits are held, so it goes low in the cycle after a payload word fills the reservoir to 32 bits.
- R8: If the word marked with `in_last` has been taken and the reservoir holds fewer bits than the next field needs, the block pulses `out_err` for one cycle. It does not raise `out_done`, and it takes the next word as a selector.
- R9: Words that arrive after channel 31 has been extracted are thrown away, up to and including the word marked `in_last`. When that word is taken, `out_err` pulses. The bank's samples and its done flag are still delivered.
- R10: A selector word that carries `in_last` produces an `out_err` pulse and no samples. The block keeps waiting for a selector.
- R11: After reset `out_valid`, `out_done` and `out_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_data | input | 32 | Selector or payload word |
| in_last | input | 1 | Offered word is the final word of the bank |
| in_ready | output | 1 | Block will take the offered word at the next edge |
| out_valid | output | 1 | One decoded sample is present |
| out_sample | output | 12 | Decoded sample, full width |
| out_chan | output | 5 | Channel number of the sample |
| out_done | output | 1 | Sample is the last of its bank |
| out_err | output | 1 | One-cycle pulse on a malformed bank |

## Verification
The bench builds the unpacker with its default values: 32 channels, 32-bit words, and 4-bit and 12-bit fields. With these values every selector pattern can be reached, from all-narrow (four payload words) to all-wide (twelve). Fields cross word boundaries at every bit offset the packing can produce. The twelve-word wide case also fills the reservoir to its limit. These defaults let the bench's own packer produce the random banks, the alternating selectors, a truncated wide bank, an overlong bank and a selector marked as last, all at the port width the block is built for.

// File: rtl/adcu_pkg.sv
package adcu_pkg;

    // Control phase of the unpacker
    typedef enum logic [1:0] {
        PH_SELECT = 2'd0,   // waiting for the per-channel width selector
        PH_BODY   = 2'd1,   // extracting fields from payload words
        PH_FLUSH  = 2'd2    // discarding surplus words up to the marked last one
    } adcu_phase_e;

endpackage

// File: rtl/adcu_field_pick.sv
// Chooses the width of the current field, tells whether the reservoir
// holds enough bits for it, and widens a narrow code by sign extension.
module adcu_field_pick #(
    parameter int NARROW_W = 4,
    parameter int WIDE_W   = 12,
    parameter int RES_W    = 64,
    parameter int CNT_W    = 7
) (
    input  logic [RES_W-1:0]  res_bits,
    input  logic [CNT_W-1:0]  res_cnt,
    input  logic              wide_sel,
    output logic [WIDE_W-1:0] field,
    output logic [CNT_W-1:0]  field_len,
    output logic              have_field
);
    localparam logic [CNT_W-1:0] NARROW_LEN = CNT_W'(NARROW_W);
    localparam logic [CNT_W-1:0] WIDE_LEN   = CNT_W'(WIDE_W);

    logic [WIDE_W-1:0] narrow_ext;

    always_comb begin
        narrow_ext = {{(WIDE_W-NARROW_W){res_bits[NARROW_W-1]}}, res_bits[NARROW_W-1:0]};
        field_len  = wide_sel ? WIDE_LEN : NARROW_LEN;
        have_field = (res_cnt >= field_len);
        field      = wide_sel ? res_bits[WIDE_W-1:0] : narrow_ext;
    end

endmodule

// File: rtl/adcu_res_merge.sv
// Removes the consumed field from the bottom of the bit reservoir and
// appends a newly accepted word directly above the remaining bits.
module adcu_res_merge #(
    parameter int WORD_W = 32,
    parameter int RES_W  = 64,
    parameter int CNT_W  = 7
) (
    input  logic [RES_W-1:0]  res_bits,
    input  logic [CNT_W-1:0]  res_cnt,
    input  logic [CNT_W-1:0]  drop_len,
    input  logic              append,
    input  logic [WORD_W-1:0] word,
    output logic [RES_W-1:0]  nxt_bits,
    output logic [CNT_W-1:0]  nxt_cnt
);
    localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_W);

    logic [RES_W-1:0] kept;
    logic [CNT_W-1:0] kept_cnt;
    logic [RES_W-1:0] placed;

    always_comb begin
        kept     = res_bits >> drop_len;
        kept_cnt = res_cnt - drop_len;
        placed   = {{(RES_W-WORD_W){1'b0}}, word} << kept_cnt;
        if (append) begin
            nxt_bits = kept | placed;
            nxt_cnt  = kept_cnt + WORD_LEN;
        end else begin
            nxt_bits = kept;
            nxt_cnt  = kept_cnt;
        end
    end

endmodule

// File: rtl/adcu_bank_unpacker.sv
module adcu_bank_unpacker #(
    parameter int NUM_CH   = 32,
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 4,
    parameter int WIDE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_sample,
    output logic [$clog2(NUM_CH)-1:0] out_chan,
    output logic              out_done,
    output logic              out_err
);
    import adcu_pkg::*;

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int RES_W = 2 * WORD_W;
    localparam int CNT_W = $clog2(RES_W + 1);
    localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_W);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

    typedef struct packed {
        adcu_phase_e       phase;
        logic [NUM_CH-1:0] sel;
        logic [RES_W-1:0]  bits;
        logic [CNT_W-1:0]  cnt;
        logic [CH_W-1:0]   chan;
        logic              last_in;
        logic              ov;
        logic [WIDE_W-1:0] osamp;
        logic [CH_W-1:0]   ochan;
        logic              odone;
        logic              oerr;
    } unp_state_t;

    unp_state_t st_q, st_d;

    logic [WIDE_W-1:0] fld;
    logic [CNT_W-1:0]  fld_len;
    logic              fld_ok;
    logic              take;
    logic              extract;
    logic [CNT_W-1:0]  drop_len;
    logic [RES_W-1:0]  mrg_bits;
    logic [CNT_W-1:0]  mrg_cnt;

    adcu_field_pick #(
        .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .RES_W(RES_W), .CNT_W(CNT_W)
    ) u_pick (
        .res_bits  (st_q.bits),
        .res_cnt   (st_q.cnt),
        .wide_sel  (st_q.sel[st_q.chan]),
        .field     (fld),
        .field_len (fld_len),
        .have_field(fld_ok)
    );

    adcu_res_merge #(
        .WORD_W(WORD_W), .RES_W(RES_W), .CNT_W(CNT_W)
    ) u_merge (
        .res_bits(st_q.bits),
        .res_cnt (st_q.cnt),
        .drop_len(drop_len),
        .append  (take && st_q.phase == PH_BODY),
        .word    (in_data),
        .nxt_bits(mrg_bits),
        .nxt_cnt (mrg_cnt)
    );

    // Ready depends on registered state only
    always_comb begin
        case (st_q.phase)
            PH_SELECT: in_ready = 1'b1;
            PH_BODY:   in_ready = !st_q.last_in && (st_q.cnt < WORD_LEN);
            PH_FLUSH:  in_ready = 1'b1;
            default:   in_ready = 1'b0;
        endcase
    end

    always_comb begin
        take     = in_valid && in_ready;
        extract  = (st_q.phase == PH_BODY) && fld_ok;
        drop_len = extract ? fld_len : '0;

        st_d       = st_q;
        st_d.ov    = 1'b0;
        st_d.odone = 1'b0;
        st_d.oerr  = 1'b0;

        case (st_q.phase)
            PH_SELECT: begin
                if (take) begin
                    if (in_last) begin
                        st_d.oerr = 1'b1;
                    end else begin
                        st_d.sel     = in_data[NUM_CH-1:0];
                        st_d.bits    = '0;
                        st_d.cnt     = '0;
                        st_d.chan    = '0;
                        st_d.last_in = 1'b0;
                        st_d.phase   = PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                st_d.bits = mrg_bits;
                st_d.cnt  = mrg_cnt;
                if (take && in_last) begin
                    st_d.last_in = 1'b1;
                end
                if (extract) begin
                    st_d.ov    = 1'b1;
                    st_d.osamp = fld;
                    st_d.ochan = st_q.chan;
                    st_d.chan  = st_q.chan + CH_W'(1);
                    if (st_q.chan == LAST_CH) begin
                        st_d.odone = 1'b1;
                        if (st_q.last_in) begin
                            st_d.phase = PH_SELECT;
                        end else if (take && in_last) begin
                            st_d.oerr  = 1'b1;
                            st_d.phase = PH_SELECT;
                        end else begin
                            st_d.phase = PH_FLUSH;
                        end
                    end
                end else if (st_q.last_in) begin
                    st_d.oerr  = 1'b1;
                    st_d.phase = PH_SELECT;
                end
            end
            PH_FLUSH: begin
                if (take && in_last) begin
                    st_d.oerr  = 1'b1;
                    st_d.phase = PH_SELECT;
                end
            end
            default: st_d.phase = PH_SELECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_SELECT;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.ov;
    assign out_sample = st_q.osamp;
    assign out_chan   = st_q.ochan;
    assign out_done   = st_q.odone;
    assign out_err    = st_q.oerr;

endmodule

// File: rtl/adcu_checker.sv
module adcu_checker #(
    parameter int NUM_CH = 32,
    parameter int CH_W   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            out_valid,
    input logic [CH_W-1:0] out_chan,
    input logic            out_done,
    input logic            out_err
);
    // R5: done only travels with the final channel
    p_done_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_valid && out_chan == CH_W'(NUM_CH - 1)));

    // R4: back-to-back samples within a bank step the channel by one
    p_chan_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(out_done))
            |-> (out_chan == $past(out_chan) + CH_W'(1)));

    // R7: after a bank completes the block is again open for a selector
    p_ready_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !out_err) |=> in_ready);

    // R8: an error always leaves the block waiting for a selector
    p_err_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> in_ready);

    // R6: nothing is emitted in the cycle after the final channel
    p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_valid);

endmodule

bind adcu_bank_unpacker adcu_checker #(
    .NUM_CH(NUM_CH), .CH_W($clog2(NUM_CH))
) u_adcu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_done (out_done),
    .out_err  (out_err)
);

// File: tb/adcu_bank_unpacker_test.sv
module adcu_bank_unpacker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [11:0] out_sample;
    logic [4:0]  out_chan;
    logic        out_done;
    logic        out_err;

    adcu_bank_unpacker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_sample(out_sample), .out_chan(out_chan), .out_done(out_done),
        .out_err(out_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int mon_idx = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int first_cyc = 0;
    int last_cyc = 0;
    logic [31:0] cur_sel;
    logic [11:0] exp_s [32];
    logic [31:0] words [12];
    int nwords;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compares every strobe against the bench's packed reference
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (out_valid) begin
                if (mon_idx < 32) begin
                    chk(out_chan == 5'(mon_idx), "R4 chan", int'(out_chan), mon_idx);
                    if (cur_sel[mon_idx])
                        chk(out_sample == exp_s[mon_idx], "R2 wide sample", int'(out_sample), int'(exp_s[mon_idx]));
                    else
                        chk(out_sample == exp_s[mon_idx], "R3 narrow sample", int'(out_sample), int'(exp_s[mon_idx]));
                    chk(out_done == (mon_idx == 31), "R5 done", int'(out_done), int'(mon_idx == 31));
                    if (mon_idx == 0) first_cyc = cyc;
                    if (mon_idx == 31) last_cyc = cyc;
                end else begin
                    chk(1'b0, "R4 surplus strobe", mon_idx, 31);
                end
                mon_idx = mon_idx + 1;
            end
            if (out_done) done_cnt = done_cnt + 1;
            if (out_err) err_cnt = err_cnt + 1;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Packs random samples for the selector into words; fills exp_s
    task automatic build(input logic [31:0] sel);
        logic [383:0] stream;
        int pos;
        stream = '0;
        pos = 0;
        cur_sel = sel;
        for (int ch = 0; ch < 32; ch++) begin
            logic [11:0] v;
            int w;
            v = 12'($urandom);
            w = sel[ch] ? 12 : 4;
            for (int b = 0; b < w; b++) stream[pos + b] = v[b];
            pos += w;
            exp_s[ch] = sel[ch] ? v : {{8{v[3]}}, v[3:0]};
        end
        nwords = (pos + 31) / 32;
        for (int k = 0; k < 12; k++) words[k] = stream[k*32 +: 32];
    endtask

    task automatic send_word(input logic [31:0] w, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
        while (1) begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle_wait(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Sends a full, well-formed bank and checks its totals
    task automatic run_bank(input logic [31:0] sel, input string tag);
        int d0, e0;
        build(sel);
        d0 = done_cnt;
        e0 = err_cnt;
        mon_idx = 0;
        send_word(sel, 1'b0);
        for (int k = 0; k < nwords; k++) send_word(words[k], k == nwords - 1);
        idle_wait(20);
        chk(mon_idx == 32, {tag, " R1 channel count"}, mon_idx, 32);
        chk(done_cnt - d0 == 1, {tag, " R5 done count"}, done_cnt - d0, 1);
        chk(err_cnt == e0, {tag, " R8 no error"}, err_cnt - e0, 0);
    endtask

    initial begin
        int d0, e0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!out_valid && !out_done && !out_err, "R11 outputs idle in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 ready after reset", int'(in_ready), 1);
        chk(!out_valid && !out_err, "R11 outputs idle after reset", int'(out_valid), 0);

        // Corner selectors
        run_bank(32'h0000_0000, "narrow");
        chk(nwords == 4, "R1 narrow word count", nwords, 4);
        run_bank(32'hFFFF_FFFF, "wide");
        chk(nwords == 12, "R6 wide bank uses 12 words", nwords, 12);
        chk(last_cyc - first_cyc == 31, "R6 one channel per cycle", last_cyc - first_cyc, 31);
        run_bank(32'h5555_5555, "alt5");
        chk(last_cyc - first_cyc == 31, "R6 alternating throughput", last_cyc - first_cyc, 31);
        run_bank(32'hAAAA_AAAA, "altA");

        // R7 back-pressure: narrow bank, one word fills the reservoir to 32 bits
        build(32'h0000_0000);
        mon_idx = 0;
        send_word(32'h0, 1'b0);
        send_word(words[0], 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R7 ready low at 32 bits", int'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R7 ready back after a field", int'(in_ready), 1);
        for (int k = 1; k < 4; k++) send_word(words[k], k == 3);
        idle_wait(20);
        chk(mon_idx == 32, "R7 bank completes", mon_idx, 32);

        // Random selectors
        for (int i = 0; i < 30; i++) run_bank($urandom, "rand");

        // R8 truncated wide bank: 5 of 12 words
        build(32'hFFFF_FFFF);
        d0 = done_cnt; e0 = err_cnt; mon_idx = 0;
        send_word(32'hFFFF_FFFF, 1'b0);
        for (int k = 0; k < 5; k++) send_word(words[k], k == 4);
        idle_wait(20);
        chk(mon_idx == 13, "R8 channels before truncation", mon_idx, 13);
        chk(err_cnt - e0 == 1, "R8 error pulse", err_cnt - e0, 1);
        chk(done_cnt == d0, "R8 no done", done_cnt - d0, 0);
        chk(in_ready == 1'b1, "R8 waiting for selector", int'(in_ready), 1);
        run_bank($urandom, "after_trunc");

        // R9 overlong bank: two surplus words, last marked
        build(32'h0F0F_00FF);
        d0 = done_cnt; e0 = err_cnt; mon_idx = 0;
        send_word(32'h0F0F_00FF, 1'b0);
        for (int k = 0; k < nwords; k++) send_word(words[k], 1'b0);
        send_word(32'hDEAD_BEEF, 1'b0);
        send_word(32'hFFFF_FFFF, 1'b1);
        idle_wait(20);
        chk(mon_idx == 32, "R9 samples delivered", mon_idx, 32);
        chk(done_cnt - d0 == 1, "R9 done delivered", done_cnt - d0, 1);
        chk(err_cnt - e0 == 1, "R9 error pulse", err_cnt - e0, 1);
        run_bank($urandom, "after_long");

        // R10 selector marked as last
        e0 = err_cnt; mon_idx = 0;
        send_word(32'h1234_5678, 1'b1);
        idle_wait(5);
        chk(err_cnt - e0 == 1, "R10 error on lone selector", err_cnt - e0, 1);
        chk(mon_idx == 0, "R10 no samples", mon_idx, 0);
        run_bank(32'h8000_0001, "after_lone");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule